// File: doc/BRIEF.md
# Translation-Miss Assist Register Loader

When the address translator reports a miss, this block fills a bank of six 32-bit assist words in one clock. A software miss handler can then install a new translation entry with little work. The values come from several places. A defaults word supplies the table-select, page-size and storage-attribute fields. The faulting address supplies the page number. One of three process-ID inputs, chosen by a selector field, supplies the entry's ID tag. An internal round-robin counter over a power-of-two way count supplies the entry to replace and the one after it. The same clock also captures the faulting address and, for data misses, whether the access was a store.

The miss strobe is a single-cycle event, not a data stream. The block takes every strobe and applies no back-pressure. The handler reads the assist words as plain outputs. It can overwrite any of them through a simple write port. A write is applied only in a cycle with no miss strobe. When both arrive together, the miss wins and the write is lost.

Top module: `tlbmiss_assist_loader`

## Requirements
- R1: After reset, every assist word, `fault_addr` and `syn_store` are zero, and the victim counter is zero.
- R2: On a miss, the table-select default `dflt_cfg[29:28]` goes to `sel_word[29:28]`, the size default `dflt_cfg[11:7]` goes to `tag_word[11:7]`, and the attribute default `dflt_cfg[4:0]` goes to `epn_word[4:0]`. `rpn_word` and `rpnhi_word` become zero.
- R3: On a miss, the space bit `tag_word[12]` and the search-space bit `srch_word[0]` are both set when the access is a fetch with `iside_as`=1 or a data access with `dside_as`=1. Otherwise both are cleared.
- R4: On a miss, `tag_word[31]` (valid) is set, and `epn_word[31:12]` takes `miss_addr[31:12]`. All other bits of these words not named in R2, R3, R5 or R7 are zero.
- R5: On a miss, `dflt_cfg[17:16]` chooses the value loaded into `tag_word[16+PID_W-1:16]`: 0 gives `pid0`, 1 gives `pid1`, 2 gives `pid2`, and 3 gives zero.
- R6: On a miss, `pid0` is placed in `srch_word[16+PID_W-1:16]`.
- R7: On a miss, `sel_word[16 +: WAY_W]` takes the current victim count. The count then advances by one modulo WAYS, and the new value goes to `sel_word[WAY_W-1:0]`. The count wraps from WAYS-1 to 0.
- R8: On every miss, `fault_addr` takes `miss_addr`. On a data miss (`acc_fetch`=0), `syn_store` takes `acc_store`. On a fetch miss, `syn_store` keeps its value.
- R9: In a cycle with neither a miss strobe nor a write, all outputs hold.
- R10: With `wr_en`=1 and no miss strobe, `wr_data` is written to the word chosen by `wr_idx`: 0 sel, 1 tag, 2 epn, 3 rpn, 6 srch, 7 rpnhi. Indices 4 and 5 change nothing. A write in the same cycle as a miss is dropped. Writes never move the victim counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_stb | input | 1 | Single-cycle miss event |
| miss_addr | input | 32 | Faulting effective address |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_store | input | 1 | 1 = store (data accesses only) |
| iside_as | input | 1 | Instruction address-space bit |
| dside_as | input | 1 | Data address-space bit |
| pid0 | input | PID_W | Process ID 0 |
| pid1 | input | PID_W | Process ID 1 |
| pid2 | input | PID_W | Process ID 2 |
| dflt_cfg | input | 32 | Defaults word |
| wr_en | input | 1 | Software write strobe |
| wr_idx | input | 3 | Target word of a software write |
| wr_data | input | 32 | Software write data |
| sel_word | output | 32 | Table select, entry select, next victim |
| tag_word | output | 32 | Valid, ID tag, space bit, size |
| epn_word | output | 32 | Page number and attributes |
| rpn_word | output | 32 | Real page number |
| srch_word | output | 32 | Search ID and search space |
| rpnhi_word | output | 32 | Real page number high part |
| fault_addr | output | 32 | Captured faulting address |
| syn_store | output | 1 | Syndrome store bit |

## Verification
The bench runs the victim counter past WAYS-1. A counter that saturates, or that writes the advanced value into both way fields, gives a wrong entry select on the next miss. It drives every selector code, including the zero code. A decoder that falls through would put a stale ID in the tag. It checks a fetch miss against a data miss for both the space bit and the store bit. A design that uses the wrong space bit, or that clears `syn_store` on a fetch, shows up here. It also writes index 4, and sends a write in the same cycle as a miss. A sloppy index decode, or a write path that takes priority over the miss, corrupts a word.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int WORD_W = 32;

  // Defaults word fields
  localparam int DF_TSEL_HI  = 29;
  localparam int DF_TSEL_LO  = 28;
  localparam int DF_TIDS_HI  = 17;
  localparam int DF_TIDS_LO  = 16;
  localparam int DF_SIZE_HI  = 11;
  localparam int DF_SIZE_LO  = 7;
  localparam int DF_ATTR_HI  = 4;
  localparam int DF_ATTR_LO  = 0;

  // Assist word field positions
  localparam int VALID_BIT   = 31;
  localparam int TS_BIT      = 12;
  localparam int TID_LSB     = 16;
  localparam int ESEL_LSB    = 16;
  localparam int NV_LSB      = 0;
  localparam int SPID_LSB    = 16;
  localparam int SAS_BIT     = 0;

  typedef enum logic [1:0] {
    TIDSRC_P0   = 2'd0,
    TIDSRC_P1   = 2'd1,
    TIDSRC_P2   = 2'd2,
    TIDSRC_ZERO = 2'd3
  } tid_src_e;

  typedef enum logic [2:0] {
    WIDX_SEL   = 3'd0,
    WIDX_TAG   = 3'd1,
    WIDX_EPN   = 3'd2,
    WIDX_RPN   = 3'd3,
    WIDX_RSV4  = 3'd4,
    WIDX_RSV5  = 3'd5,
    WIDX_SRCH  = 3'd6,
    WIDX_RPNHI = 3'd7
  } widx_e;

  typedef struct packed {
    logic [WORD_W-1:0] sel;
    logic [WORD_W-1:0] tag;
    logic [WORD_W-1:0] epn;
    logic [WORD_W-1:0] rpn;
    logic [WORD_W-1:0] srch;
    logic [WORD_W-1:0] rpnhi;
  } assist_set_t;
endpackage

// File: rtl/tlbm_victim_ctr.sv
module tlbm_victim_ctr #(
  parameter int WAYS  = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [WAY_W-1:0] cur,
  output logic [WAY_W-1:0] nxt
);
  // Power-of-two way count: natural wrap of WAY_W bits is the modulo.
  assign nxt = cur + WAY_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cur <= '0;
    else if (adv) cur <= nxt;
  end
endmodule

// File: rtl/tlbm_compose.sv
module tlbm_compose
  import tlbm_pkg::*;
#(
  parameter int PID_W     = 8,
  parameter int WAY_W     = 2,
  parameter int PAGE_BITS = 12
) (
  input  logic [WORD_W-1:0] miss_addr,
  input  logic              acc_fetch,
  input  logic              iside_as,
  input  logic              dside_as,
  input  logic [PID_W-1:0]  pid0,
  input  logic [PID_W-1:0]  pid1,
  input  logic [PID_W-1:0]  pid2,
  input  logic [WORD_W-1:0] dflt_cfg,
  input  logic [WAY_W-1:0]  vict_cur,
  input  logic [WAY_W-1:0]  vict_nxt,
  output assist_set_t       fill
);
  logic             as_hit;
  logic [PID_W-1:0] tid_val;
  tid_src_e         tid_src;
  logic             unused_cfg_bits;

  assign unused_cfg_bits = ^{dflt_cfg[31:30], dflt_cfg[27:18], dflt_cfg[15:12],
                             dflt_cfg[6:5], miss_addr[PAGE_BITS-1:0]};

  assign as_hit  = acc_fetch ? iside_as : dside_as;
  assign tid_src = tid_src_e'(dflt_cfg[DF_TIDS_HI:DF_TIDS_LO]);

  always_comb begin
    case (tid_src)
      TIDSRC_P0: tid_val = pid0;
      TIDSRC_P1: tid_val = pid1;
      TIDSRC_P2: tid_val = pid2;
      default:   tid_val = '0;
    endcase
  end

  always_comb begin
    fill = '0;
    fill.sel[DF_TSEL_HI:DF_TSEL_LO]  = dflt_cfg[DF_TSEL_HI:DF_TSEL_LO];
    fill.sel[ESEL_LSB +: WAY_W]      = vict_cur;
    fill.sel[NV_LSB +: WAY_W]        = vict_nxt;

    fill.tag[VALID_BIT]              = 1'b1;
    fill.tag[TS_BIT]                 = as_hit;
    fill.tag[DF_SIZE_HI:DF_SIZE_LO]  = dflt_cfg[DF_SIZE_HI:DF_SIZE_LO];
    fill.tag[TID_LSB +: PID_W]       = tid_val;

    fill.epn[WORD_W-1:PAGE_BITS]     = miss_addr[WORD_W-1:PAGE_BITS];
    fill.epn[DF_ATTR_HI:DF_ATTR_LO]  = dflt_cfg[DF_ATTR_HI:DF_ATTR_LO];

    fill.srch[SPID_LSB +: PID_W]     = pid0;
    fill.srch[SAS_BIT]               = as_hit;
  end
endmodule

// File: rtl/tlbm_regs.sv
module tlbm_regs
  import tlbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_stb,
  input  assist_set_t       fill,
  input  logic [WORD_W-1:0] miss_addr,
  input  logic              acc_fetch,
  input  logic              acc_store,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output assist_set_t       held,
  output logic [WORD_W-1:0] fault_q,
  output logic              syn_q
);
  assist_set_t sw_next;

  // Software write view: only the chosen word changes.
  always_comb begin
    sw_next = held;
    case (widx_e'(wr_idx))
      WIDX_SEL:   sw_next.sel   = wr_data;
      WIDX_TAG:   sw_next.tag   = wr_data;
      WIDX_EPN:   sw_next.epn   = wr_data;
      WIDX_RPN:   sw_next.rpn   = wr_data;
      WIDX_SRCH:  sw_next.srch  = wr_data;
      WIDX_RPNHI: sw_next.rpnhi = wr_data;
      default:    sw_next       = held;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= '0;
      fault_q <= '0;
      syn_q   <= 1'b0;
    end else if (miss_stb) begin
      held    <= fill;
      fault_q <= miss_addr;
      if (!acc_fetch) syn_q <= acc_store;
    end else if (wr_en) begin
      held    <= sw_next;
    end
  end
endmodule

// File: rtl/tlbmiss_assist_loader.sv
module tlbmiss_assist_loader
  import tlbm_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int PID_W     = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_stb,
  input  logic [31:0]       miss_addr,
  input  logic              acc_fetch,
  input  logic              acc_store,
  input  logic              iside_as,
  input  logic              dside_as,
  input  logic [PID_W-1:0]  pid0,
  input  logic [PID_W-1:0]  pid1,
  input  logic [PID_W-1:0]  pid2,
  input  logic [31:0]       dflt_cfg,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [31:0]       wr_data,
  output logic [31:0]       sel_word,
  output logic [31:0]       tag_word,
  output logic [31:0]       epn_word,
  output logic [31:0]       rpn_word,
  output logic [31:0]       srch_word,
  output logic [31:0]       rpnhi_word,
  output logic [31:0]       fault_addr,
  output logic              syn_store
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAY_W-1:0] vict_cur;
  logic [WAY_W-1:0] vict_nxt;
  assist_set_t      fill;
  assist_set_t      held;

  tlbm_victim_ctr #(.WAYS(WAYS)) u_vict (
    .clk (clk),
    .rst_n (rst_n),
    .adv (miss_stb),
    .cur (vict_cur),
    .nxt (vict_nxt)
  );

  tlbm_compose #(.PID_W(PID_W), .WAY_W(WAY_W), .PAGE_BITS(PAGE_BITS)) u_comp (
    .miss_addr (miss_addr),
    .acc_fetch (acc_fetch),
    .iside_as (iside_as),
    .dside_as (dside_as),
    .pid0 (pid0),
    .pid1 (pid1),
    .pid2 (pid2),
    .dflt_cfg (dflt_cfg),
    .vict_cur (vict_cur),
    .vict_nxt (vict_nxt),
    .fill (fill)
  );

  tlbm_regs u_regs (
    .clk (clk),
    .rst_n (rst_n),
    .miss_stb (miss_stb),
    .fill (fill),
    .miss_addr (miss_addr),
    .acc_fetch (acc_fetch),
    .acc_store (acc_store),
    .wr_en (wr_en),
    .wr_idx (wr_idx),
    .wr_data (wr_data),
    .held (held),
    .fault_q (fault_addr),
    .syn_q (syn_store)
  );

  assign sel_word   = held.sel;
  assign tag_word   = held.tag;
  assign epn_word   = held.epn;
  assign rpn_word   = held.rpn;
  assign srch_word  = held.srch;
  assign rpnhi_word = held.rpnhi;
endmodule

// File: rtl/tlbm_checker.sv
module tlbm_checker #(
  parameter int WAYS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        miss_stb,
  input logic [31:0] miss_addr,
  input logic        acc_fetch,
  input logic        acc_store,
  input logic        iside_as,
  input logic        dside_as,
  input logic        wr_en,
  input logic [2:0]  wr_idx,
  input logic [31:0] sel_word,
  input logic [31:0] tag_word,
  input logic [31:0] epn_word,
  input logic [31:0] rpn_word,
  input logic [31:0] srch_word,
  input logic [31:0] rpnhi_word,
  input logic [31:0] fault_addr,
  input logic        syn_store
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAY_W-1:0] esel_inc;
  logic             space_now;
  logic             rsv_write;
  assign esel_inc  = sel_word[16 +: WAY_W] + WAY_W'(1);
  assign space_now = acc_fetch ? iside_as : dside_as;
  assign rsv_write = wr_en && (wr_idx == 3'd4 || wr_idx == 3'd5);

  assert_clear_rpn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_stb |=> (rpn_word == 32'd0 && rpnhi_word == 32'd0));

  assert_space_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_stb |=> (tag_word[12] == $past(space_now) && srch_word[0] == $past(space_now)));

  assert_valid_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_stb |=> (tag_word[31] && epn_word[31:12] == $past(miss_addr[31:12])));

  assert_victim_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_stb |=> (sel_word[WAY_W-1:0] == esel_inc));

  assert_fault_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_stb |=> (fault_addr == $past(miss_addr)));

  assert_data_syn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_stb && !acc_fetch) |=> (syn_store == $past(acc_store)));

  assert_fetch_syn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_stb && acc_fetch) |=> $stable(syn_store));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_stb && !wr_en) |=> ($stable(sel_word) && $stable(tag_word) &&
      $stable(epn_word) && $stable(rpn_word) && $stable(srch_word) &&
      $stable(rpnhi_word) && $stable(fault_addr) && $stable(syn_store)));

  assert_rsv_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_stb && rsv_write) |=> ($stable(sel_word) && $stable(tag_word) &&
      $stable(epn_word) && $stable(rpn_word) && $stable(srch_word) &&
      $stable(rpnhi_word)));
endmodule

bind tlbmiss_assist_loader tlbm_checker #(.WAYS(WAYS)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .miss_stb (miss_stb),
  .miss_addr (miss_addr),
  .acc_fetch (acc_fetch),
  .acc_store (acc_store),
  .iside_as (iside_as),
  .dside_as (dside_as),
  .wr_en (wr_en),
  .wr_idx (wr_idx),
  .sel_word (sel_word),
  .tag_word (tag_word),
  .epn_word (epn_word),
  .rpn_word (rpn_word),
  .srch_word (srch_word),
  .rpnhi_word (rpnhi_word),
  .fault_addr (fault_addr),
  .syn_store (syn_store)
);

// File: tb/tlbmiss_assist_loader_bench.sv
module tlbmiss_assist_loader_bench;
  localparam int WAYS  = 4;
  localparam int PID_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_stb = 1'b0;
  logic [31:0] miss_addr = '0;
  logic acc_fetch = 1'b0, acc_store = 1'b0, iside_as = 1'b0, dside_as = 1'b0;
  logic [PID_W-1:0] pid0 = 8'h5A, pid1 = 8'hC3, pid2 = 8'h71;
  logic [31:0] dflt_cfg = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] sel_word, tag_word, epn_word, rpn_word, srch_word, rpnhi_word, fault_addr;
  logic syn_store;

  always #4 clk = ~clk;

  tlbmiss_assist_loader #(.WAYS(WAYS), .PID_W(PID_W)) u_tlbmiss_assist_loader (
    .clk(clk), .rst_n(rst_n), .miss_stb(miss_stb), .miss_addr(miss_addr),
    .acc_fetch(acc_fetch), .acc_store(acc_store), .iside_as(iside_as),
    .dside_as(dside_as), .pid0(pid0), .pid1(pid1), .pid2(pid2),
    .dflt_cfg(dflt_cfg), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sel_word(sel_word), .tag_word(tag_word), .epn_word(epn_word),
    .rpn_word(rpn_word), .srch_word(srch_word), .rpnhi_word(rpnhi_word),
    .fault_addr(fault_addr), .syn_store(syn_store));

  typedef struct {
    logic [31:0] w [8];
    logic        syn;
    int          due;
    string       req;
  } exp_t;

  exp_t  exp_q [$];
  exp_t  mdl;
  exp_t  got;
  int    vict = 0;
  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare each expected item in the cycle it becomes due.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      got = exp_q.pop_front();
      checks++;
      if ({sel_word, tag_word, epn_word, rpn_word, srch_word, rpnhi_word, fault_addr, syn_store} !=
          {got.w[0], got.w[1], got.w[2], got.w[3], got.w[6], got.w[7], got.w[4], got.syn}) begin
        failures++;
        $display("FAIL %s: got sel=%h tag=%h epn=%h rpn=%h srch=%h rpnhi=%h fa=%h syn=%b exp sel=%h tag=%h epn=%h rpn=%h srch=%h rpnhi=%h fa=%h syn=%b",
          got.req, sel_word, tag_word, epn_word, rpn_word, srch_word, rpnhi_word, fault_addr, syn_store,
          got.w[0], got.w[1], got.w[2], got.w[3], got.w[6], got.w[7], got.w[4], got.syn);
      end
    end
  end

  task automatic push_exp(input string req);
    mdl.due = cyc + 1;
    mdl.req = req;
    exp_q.push_back(mdl);
  endtask

  // Expected fill computed from the requirements (w[4] models fault_addr).
  task automatic model_miss(input logic [31:0] a, input logic f, input logic st,
                            input logic is, input logic ds, input logic [31:0] d);
    logic sp;
    logic [31:0] tid;
    sp = f ? is : ds;
    case (d[17:16])
      2'd0: tid = {24'd0, pid0};
      2'd1: tid = {24'd0, pid1};
      2'd2: tid = {24'd0, pid2};
      default: tid = 32'd0;
    endcase
    mdl.w[0] = (d & 32'h3000_0000) | (32'(vict) << 16) | 32'((vict + 1) % WAYS);
    mdl.w[1] = 32'h8000_0000 | (d & 32'h0000_0F80) | (32'(sp) << 12) | (tid << 16);
    mdl.w[2] = (a & 32'hFFFF_F000) | (d & 32'h0000_001F);
    mdl.w[3] = 32'd0;
    mdl.w[6] = ({24'd0, pid0} << 16) | 32'(sp);
    mdl.w[7] = 32'd0;
    mdl.w[4] = a;
    if (!f) mdl.syn = st;
    vict = (vict + 1) % WAYS;
  endtask

  task automatic do_miss(input logic [31:0] a, input logic f, input logic st,
                         input logic is, input logic ds, input logic [31:0] d,
                         input logic with_wr, input string req);
    @(negedge clk);
    miss_addr = a; acc_fetch = f; acc_store = st; iside_as = is; dside_as = ds;
    dflt_cfg = d; miss_stb = 1'b1;
    wr_en = with_wr; wr_idx = 3'd3; wr_data = 32'hDEAD_BEEF;
    model_miss(a, f, st, is, ds, d);
    push_exp(req);
    @(negedge clk);
    miss_stb = 1'b0; wr_en = 1'b0;
  endtask

  task automatic do_write(input logic [2:0] idx, input logic [31:0] data, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = data;
    if (idx != 3'd4 && idx != 3'd5) mdl.w[idx] = data;
    push_exp(req);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_idle(input string req);
    @(negedge clk);
    miss_addr = 32'hFFFF_FFFF; acc_store = ~acc_store; dflt_cfg = 32'hFFFF_FFFF;
    push_exp(req);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    foreach (mdl.w[i]) mdl.w[i] = '0;
    mdl.syn = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    do_idle("R1 reset state");

    // tsel=1, tid sel=PID0, size=5, attr=0x0A; data load, data space set
    do_miss(32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1000_028A, 1'b0, "R2 R3 R5 R6 R8 data load");
    // tid sel=PID1, data store, data space clear
    do_miss(32'hABCD_E001, 1'b0, 1'b1, 1'b1, 1'b0, 32'h2001_0F9F, 1'b0, "R3 R5 R8 data store");
    // fetch with instruction space set, tid sel=PID2; store bit must hold
    do_miss(32'h0040_0FFC, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0002_0001, 1'b0, "R3 R5 R8 fetch keeps syn");
    // fetch with instruction space clear, tid sel=zero code; victim 3 wraps
    do_miss(32'hFFFF_F000, 1'b1, 1'b1, 1'b0, 1'b1, 32'h3003_0000, 1'b0, "R3 R5 R7 wrap");
    do_miss(32'h8000_1234, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, "R4 R7 after wrap");
    do_idle("R9 hold");
    do_write(3'd0, 32'h1111_0001, "R10 write sel");
    do_write(3'd1, 32'h2222_0002, "R10 write tag");
    do_write(3'd2, 32'h3333_0003, "R10 write epn");
    do_write(3'd3, 32'h4444_0004, "R10 write rpn");
    do_write(3'd4, 32'h5555_0005, "R10 reserved index 4");
    do_write(3'd5, 32'h6666_0006, "R10 reserved index 5");
    do_write(3'd6, 32'h7777_0007, "R10 write srch");
    do_write(3'd7, 32'h8888_0008, "R10 write rpnhi");
    do_idle("R9 hold after writes");
    // write together with miss is dropped; victim unaffected by writes
    do_miss(32'h0BAD_C000, 1'b0, 1'b1, 1'b0, 1'b1, 32'h1001_0180, 1'b1, "R10 R7 miss beats write");
    do_miss(32'h0000_3000, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_0C00, 1'b0, "R2 R7 R8 fetch");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: got %0d pending exp 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule